// File: doc/BRIEF.md
# Compare Output Unit with Software Force

This block owns one waveform output pin of an 8-bit timer. On every counter tick it compares the running count with a compare value. When they are equal it applies the action chosen by a two-bit output mode to the pin: hold, toggle, drive low or drive high. The same event also sets a sticky compare flag. If clear-on-match is enabled, it also raises a one-cycle request to clear the counter.

A write strobe lets software apply the programmed pin action at once, without waiting for a match. A forced action changes only the pin. It never sets the compare flag and never requests a counter clear. The strobe is gated off completely while the timer runs in PWM mode. The PWM waveform generator is not part of this block. All outputs are registered and change on the clock edge that samples the event.

Top module: `waveform_cmp_unit`

## Requirements
- R1: After synchronous reset, `pin_out`, `cmp_flag` and `cnt_clear_req` are all 0.
- R2: A match is `cnt_tick`=1 with `cnt_value`==`cmp_value`. A match applies the `out_mode` action to `pin_out` on the next edge. The encodings are 2'b01 toggle, 2'b10 drive 0 and 2'b11 drive 1.
- R3: Equal count and compare values with `cnt_tick`=0 change no output.
- R4: A `force_wr` pulse with `pwm_en`=0 applies the `out_mode` action to `pin_out` on the next edge, with no match present.
- R5: A forced action never sets `cmp_flag`.
- R6: A forced action never raises `cnt_clear_req`, even with `clr_on_match`=1.
- R7: While `pwm_en`=1, `force_wr` leaves `pin_out` unchanged.
- R8: A match sets `cmp_flag` on the next edge. The flag stays set until a `flag_ack` cycle without a match clears it; a match in the same cycle as `flag_ack` wins.
- R9: A match with `clr_on_match`=1 raises `cnt_clear_req` for exactly one cycle. With `clr_on_match`=0 a match raises no request.
- R10: A force and a match in the same cycle apply the pin action once: in toggle mode the pin inverts exactly once.
- R11: Mode 2'b00 leaves `pin_out` unchanged on both matches and forces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Counter advance qualifier for this cycle |
| cnt_value | input | CNT_W | Current counter value |
| cmp_value | input | CNT_W | Compare register value |
| out_mode | input | 2 | Pin action: 00 hold, 01 toggle, 10 low, 11 high |
| pwm_en | input | 1 | Timer is in PWM mode; gates the force strobe |
| clr_on_match | input | 1 | Request a counter clear on real matches |
| force_wr | input | 1 | Write-only force strobe |
| flag_ack | input | 1 | Clears the compare flag |
| pin_out | output | 1 | Waveform output pin |
| cmp_flag | output | 1 | Sticky compare flag |
| cnt_clear_req | output | 1 | One-cycle counter clear request |

## Verification
Each output is a single register, so any corruption of state shows up at a port on the edge after the triggering cycle. A force that leaks into the flag or clear path appears as a spurious `cmp_flag` or `cnt_clear_req` one cycle after the strobe. A force that ignores the PWM gate shows as a pin edge in that same cycle. A double-applied toggle, when force and match coincide, leaves the pin at its old level, and the next sample exposes it at once.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;

    typedef enum logic [1:0] {
        PM_HOLD   = 2'b00,
        PM_TOGGLE = 2'b01,
        PM_LOW    = 2'b10,
        PM_HIGH   = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic hit;     // real compare event
        logic forced;  // accepted software force
    } pin_evt_t;

    function automatic logic next_pin(input pin_mode_e mode, input logic cur);
        logic r;
        case (mode)
            PM_TOGGLE: r = ~cur;
            PM_LOW:    r = 1'b0;
            PM_HIGH:   r = 1'b1;
            default:   r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cmp_match_detect.sv
module cmp_match_detect #(
    parameter int CNT_W = 8
) (
    input  logic             cnt_tick,
    input  logic [CNT_W-1:0] cnt_value,
    input  logic [CNT_W-1:0] cmp_value,
    output logic             hit
);
    always_comb begin
        hit = cnt_tick && (cnt_value == cmp_value);
    end
endmodule

// File: rtl/cmp_force_gate.sv
module cmp_force_gate (
    input  logic force_wr,
    input  logic pwm_en,
    output logic forced
);
    // Strobe is not stored anywhere: it acts in its own cycle only.
    always_comb begin
        forced = force_wr && !pwm_en;
    end
endmodule

// File: rtl/cmp_pin_driver.sv
module cmp_pin_driver
    import cmp_out_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_evt_t  evt,
    input  pin_mode_e mode,
    input  logic      clr_on_match,
    input  logic      flag_ack,
    output logic      pin_out,
    output logic      cmp_flag,
    output logic      cnt_clear_req
);
    logic fire;

    always_comb begin
        fire = evt.hit || evt.forced;   // single action when both coincide
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_out       <= 1'b0;
            cmp_flag      <= 1'b0;
            cnt_clear_req <= 1'b0;
        end else begin
            if (fire) begin
                pin_out <= next_pin(mode, pin_out);
            end
            if (evt.hit) begin
                cmp_flag <= 1'b1;
            end else if (flag_ack) begin
                cmp_flag <= 1'b0;
            end
            cnt_clear_req <= evt.hit && clr_on_match;
        end
    end
endmodule

// File: rtl/waveform_cmp_unit.sv
module waveform_cmp_unit
    import cmp_out_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_tick,
    input  logic [CNT_W-1:0] cnt_value,
    input  logic [CNT_W-1:0] cmp_value,
    input  logic [1:0]       out_mode,
    input  logic             pwm_en,
    input  logic             clr_on_match,
    input  logic             force_wr,
    input  logic             flag_ack,
    output logic             pin_out,
    output logic             cmp_flag,
    output logic             cnt_clear_req
);
    pin_evt_t evt;
    logic     hit_w;
    logic     forced_w;

    cmp_match_detect #(.CNT_W(CNT_W)) u_match (
        .cnt_tick  (cnt_tick),
        .cnt_value (cnt_value),
        .cmp_value (cmp_value),
        .hit       (hit_w)
    );

    cmp_force_gate u_force (
        .force_wr (force_wr),
        .pwm_en   (pwm_en),
        .forced   (forced_w)
    );

    always_comb begin
        evt.hit    = hit_w;
        evt.forced = forced_w;
    end

    cmp_pin_driver u_drv (
        .clk           (clk),
        .rst           (rst),
        .evt           (evt),
        .mode          (pin_mode_e'(out_mode)),
        .clr_on_match  (clr_on_match),
        .flag_ack      (flag_ack),
        .pin_out       (pin_out),
        .cmp_flag      (cmp_flag),
        .cnt_clear_req (cnt_clear_req)
    );
endmodule

// File: rtl/cmp_unit_checker.sv
module cmp_unit_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_tick,
    input logic [CNT_W-1:0] cnt_value,
    input logic [CNT_W-1:0] cmp_value,
    input logic [1:0]       out_mode,
    input logic             pwm_en,
    input logic             clr_on_match,
    input logic             force_wr,
    input logic             flag_ack,
    input logic             pin_out,
    input logic             cmp_flag,
    input logic             cnt_clear_req
);
    logic real_hit;
    always_comb real_hit = cnt_tick && (cnt_value == cmp_value);

    assert_force_no_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (force_wr && !real_hit && !cmp_flag) |=> !cmp_flag);

    assert_force_no_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (force_wr && !real_hit) |=> !cnt_clear_req);

    assert_pwm_blocks_force_R7: assert property (@(posedge clk) disable iff (rst)
        (pwm_en && !real_hit) |=> $stable(pin_out));

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
        real_hit |=> cmp_flag);

    assert_clear_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (real_hit && clr_on_match) |=> cnt_clear_req);

    assert_toggle_once_R10: assert property (@(posedge clk) disable iff (rst)
        (real_hit && force_wr && !pwm_en && out_mode == 2'b01) |=> (pin_out != $past(pin_out)));

    assert_hold_mode_R11: assert property (@(posedge clk) disable iff (rst)
        (out_mode == 2'b00) |=> $stable(pin_out));
endmodule

bind waveform_cmp_unit cmp_unit_checker #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cnt_tick      (cnt_tick),
    .cnt_value     (cnt_value),
    .cmp_value     (cmp_value),
    .out_mode      (out_mode),
    .pwm_en        (pwm_en),
    .clr_on_match  (clr_on_match),
    .force_wr      (force_wr),
    .flag_ack      (flag_ack),
    .pin_out       (pin_out),
    .cmp_flag      (cmp_flag),
    .cnt_clear_req (cnt_clear_req)
);

// File: tb/test_waveform_cmp_unit.sv
`timescale 1ns/100ps
module test_waveform_cmp_unit;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cnt_tick = 1'b0;
    logic [CNT_W-1:0] cnt_value = '0;
    logic [CNT_W-1:0] cmp_value = '0;
    logic [1:0]       out_mode = 2'b00;
    logic             pwm_en = 1'b0;
    logic             clr_on_match = 1'b0;
    logic             force_wr = 1'b0;
    logic             flag_ack = 1'b0;
    logic             pin_out, cmp_flag, cnt_clear_req;

    always #2.5 clk = ~clk;

    waveform_cmp_unit #(.CNT_W(CNT_W)) i_waveform_cmp_unit (
        .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .cnt_value(cnt_value),
        .cmp_value(cmp_value), .out_mode(out_mode), .pwm_en(pwm_en),
        .clr_on_match(clr_on_match), .force_wr(force_wr), .flag_ack(flag_ack),
        .pin_out(pin_out), .cmp_flag(cmp_flag), .cnt_clear_req(cnt_clear_req)
    );

    typedef struct {
        logic  pin;
        logic  flag;
        logic  clr;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    logic m_pin = 1'b0;
    logic m_flag = 1'b0;
    bit   done = 1'b0;

    // Driver: apply one cycle of stimulus on the falling edge, push expectation.
    task automatic step(input logic tick, input logic [CNT_W-1:0] cv, input logic [CNT_W-1:0] cp,
                        input logic [1:0] md, input logic pwm, input logic clr_en,
                        input logic frc, input logic ack, input string tag);
        exp_t e;
        logic hit, fire;
        @(negedge clk);
        cnt_tick = tick; cnt_value = cv; cmp_value = cp; out_mode = md;
        pwm_en = pwm; clr_on_match = clr_en; force_wr = frc; flag_ack = ack;
        hit  = tick && (cv == cp);
        fire = hit || (frc && !pwm);
        if (fire) begin
            case (md)
                2'b01: m_pin = ~m_pin;
                2'b10: m_pin = 1'b0;
                2'b11: m_pin = 1'b1;
                default: m_pin = m_pin;
            endcase
        end
        if (hit) m_flag = 1'b1;
        else if (ack) m_flag = 1'b0;
        e.pin = m_pin; e.flag = m_flag; e.clr = hit && clr_en; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: sample just after each rising edge.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_checks++;
            if (pin_out !== e.pin || cmp_flag !== e.flag || cnt_clear_req !== e.clr) begin
                n_fail++;
                $display("FAIL %s: actual pin=%b flag=%b clr=%b expected pin=%b flag=%b clr=%b",
                         e.tag, pin_out, cmp_flag, cnt_clear_req, e.pin, e.flag, e.clr);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        if (pin_out !== 1'b0 || cmp_flag !== 1'b0 || cnt_clear_req !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: actual pin=%b flag=%b clr=%b expected 0 0 0",
                     pin_out, cmp_flag, cnt_clear_req);
        end
        @(negedge clk); rst = 1'b0;
        //    tick cnt   cmp   mode   pwm clr frc ack
        step(1, 8'd5, 8'd5, 2'b01, 0, 0, 0, 0, "R2 toggle match");
        step(1, 8'd6, 8'd5, 2'b01, 0, 0, 0, 1, "R8 ack clears flag");
        step(1, 8'd5, 8'd5, 2'b01, 0, 0, 0, 1, "R8 match beats ack");
        step(0, 8'd9, 8'd9, 2'b11, 0, 1, 0, 1, "R8 ack");
        step(0, 8'd9, 8'd9, 2'b11, 0, 1, 0, 0, "R3 no tick no match");
        step(0, 8'd1, 8'd2, 2'b11, 0, 1, 1, 0, "R4 R5 R6 force set");
        step(0, 8'd1, 8'd2, 2'b10, 0, 1, 1, 0, "R4 force clear");
        step(0, 8'd1, 8'd2, 2'b11, 1, 1, 1, 0, "R7 force ignored in pwm");
        step(0, 8'd1, 8'd2, 2'b01, 1, 1, 1, 0, "R7 toggle force ignored in pwm");
        step(1, 8'hFF, 8'hFF, 2'b11, 0, 1, 0, 0, "R2 R9 set with clear req");
        step(1, 8'h00, 8'hFF, 2'b11, 0, 1, 0, 1, "R9 single pulse");
        step(1, 8'h80, 8'h80, 2'b10, 0, 0, 0, 0, "R2 R9 clear without req");
        step(1, 8'h40, 8'h40, 2'b01, 0, 0, 1, 0, "R10 force and match toggle once");
        step(1, 8'h40, 8'h40, 2'b01, 0, 0, 1, 0, "R10 force and match toggle once again");
        step(1, 8'h22, 8'h22, 2'b00, 0, 0, 0, 1, "R11 hold on match");
        step(0, 8'h22, 8'h23, 2'b00, 0, 0, 1, 1, "R11 hold on force");
        step(0, 8'h00, 8'h01, 2'b01, 0, 0, 1, 0, "R4 toggle force");
        step(0, 8'h00, 8'h01, 2'b01, 0, 0, 0, 0, "R4 idle after force");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule